// File: doc/BRIEF.md
# ETU Time-Out Counter for a Smart Card Interface

This block measures card-side deadlines in elementary time units (ETUs). A host controller uses it to police answer-to-reset, character waiting and block waiting windows. A one-cycle `etu_tick` pulse advances the counting; raw clock cycles do not. The host writes a load value into three byte registers and picks a layout and start condition through a configuration byte. When a counter expires it raises a sticky per-counter interrupt, and a status read clears it.

The block runs either as one 24-bit counter or as two independent counters. In the split layout one counter is 16 bits wide and the other is 8 bits wide. Each counter starts in one of three ways:
- when the host writes its top load byte;
- when the card I/O line shows a start bit (a falling edge); or
- in autoreload, where the counter restarts from its programmed value every time it expires.

An active-low UART reset input returns every register of the block to its default state.

Top module: `etu_timeout_ctr`

## Requirements
- R1: After `rst_n` is deasserted, `irq_o` and `busy_o` are both 2'b00.
- R2: While `uart_rst_n` is low, the load bytes, the configuration, both counters, the start-bit detector and both expiry flags are held at zero, and register writes are ignored. After `uart_rst_n` returns high, the configuration reads as "off" for both counters.
- R3: Register map on `wr_addr`: 0 is load bits 7:0, 1 is load bits 15:8, 2 is load bits 23:16, and 3 is configuration. Configuration bit 0 selects split layout. Bits 2:1 hold the start code of counter A and bits 4:3 hold the start code of counter B. Start codes: 0 off, 1 write-start, 2 start-bit, 3 autoreload.
- R4: In single layout, counter A uses all 24 load bits, with address 2 as the most significant byte. In write-start or autoreload mode, only a write to address 2 arms it. The counter loads in the second cycle after the write and expires on the N-th `etu_tick` after loading, where N is the load value. Expiry only happens on an ETU tick.
- R5: In split layout, counter A is 16 bits wide, loaded from addresses 0 and 1 and armed by a write to address 1. Counter B is 8 bits wide, loaded from address 2 and armed by a write to address 2. The two counters count and expire independently. `irq_o[0]` and `busy_o[0]` belong to A; `irq_o[1]` and `busy_o[1]` belong to B.
- R6: A load value of zero expires on the first ETU tick after arming.
- R7: A counter that is not in autoreload stops at zero when it expires. Its busy bit drops, and it does not expire again until it is rearmed.
- R8: In autoreload, an expiry reloads the programmed value, keeps the counter busy and sets the flag again on each expiry.
- R9: In start-bit mode, a high-to-low transition of `card_io`, passed through a two-flop synchronizer, arms the counter only if the counter is idle. A transition while the counter is busy does not reload it, and register writes do not arm it.
- R10: Each expiry flag is sticky and drives its `irq_o` bit directly. A `stat_rd` pulse clears both flags. An expiry in the same cycle as a read leaves the flag set.
- R11: A write to the configuration address stops both counters. Their busy bits are low on the next cycle, and the flags are unchanged.
- R12: In single layout, counter B never runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| uart_rst_n | input | 1 | Active-low UART reset bit; low returns the block to defaults |
| etu_tick | input | 1 | One-cycle pulse per elementary time unit |
| card_io | input | 1 | Card I/O line, asynchronous, idles high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| stat_rd | input | 1 | Status read pulse; clears both expiry flags |
| irq_o | output | 2 | Sticky expiry interrupts, bit 0 counter A, bit 1 counter B |
| busy_o | output | 2 | Counter running flags, bit 0 counter A, bit 1 counter B |

## Verification
Two situations are hard to reach from the ports.

The first is that the top byte carries real weight in the 24-bit layout. This needs a count of 65,536 ETUs. The stimulus holds `etu_tick` high for 65,535 consecutive cycles, checks that the counter is still busy, and then sends one more tick.

The second is a start bit arriving while the counter is already running. To reach it, the stimulus arms the counter with one falling edge and lets one tick pass. It then drives a second falling edge through the synchronizer and shows that expiry still lands on the originally scheduled tick.

// File: rtl/etu_tmo_pkg.sv
package etu_tmo_pkg;

  typedef enum logic [1:0] {
    START_OFF    = 2'd0,
    START_WRITE  = 2'd1,
    START_EDGE   = 2'd2,
    START_RELOAD = 2'd3
  } start_mode_e;

  typedef struct packed {
    start_mode_e mode_b;
    start_mode_e mode_a;
    logic        split;
  } tmo_cfg_t;

  localparam int CFG_W = $bits(tmo_cfg_t);

  function automatic logic arms_on_write(start_mode_e m);
    return (m == START_WRITE) || (m == START_RELOAD);
  endfunction

endpackage

// File: rtl/etu_tmo_regs.sv
module etu_tmo_regs
  import etu_tmo_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int LD_BYTES = 3,
  parameter int ADDR_W   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         soft_clr,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [LD_BYTES*BYTE_W-1:0]   load_q,
  output tmo_cfg_t                     cfg_q,
  output logic                         cfg_wr,
  output logic                         wr_top_q,
  output logic                         wr_mid_q
);

  localparam int CFG_ADDR = LD_BYTES;
  localparam int TOP_IDX  = LD_BYTES - 1;
  localparam int MID_IDX  = LD_BYTES - 2;

  logic     wr_ok;
  tmo_cfg_t cfg_d;
  logic     top_d;
  logic     mid_d;
  logic     unused_hi;

  assign wr_ok     = wr_en & ~soft_clr;
  assign unused_hi = ^wr_data[BYTE_W-1:CFG_W];

  // one register per load byte, each with its own write enable
  for (genvar g = 0; g < LD_BYTES; g++) begin : g_byte
    logic              hit;
    logic [BYTE_W-1:0] byte_d;
    logic [BYTE_W-1:0] byte_q;

    assign hit = wr_ok && (wr_addr == ADDR_W'(g));

    always_comb begin
      byte_d = byte_q;
      if (soft_clr)  byte_d = '0;
      else if (hit)  byte_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end

    assign load_q[g*BYTE_W +: BYTE_W] = byte_q;
  end

  assign cfg_wr = wr_ok && (wr_addr == ADDR_W'(CFG_ADDR));

  always_comb begin
    cfg_d = cfg_q;
    if (soft_clr)    cfg_d = '0;
    else if (cfg_wr) cfg_d = tmo_cfg_t'(wr_data[CFG_W-1:0]);
  end

  // write-start pulses are delayed one cycle so the counter sees the new byte
  always_comb begin
    top_d = wr_ok && (wr_addr == ADDR_W'(TOP_IDX));
    mid_d = wr_ok && (wr_addr == ADDR_W'(MID_IDX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      wr_top_q <= 1'b0;
      wr_mid_q <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      wr_top_q <= top_d;
      wr_mid_q <= mid_d;
    end
  end

endmodule

// File: rtl/etu_io_fall.sv
module etu_io_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic line,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;
  logic              prev_d;

  // idle level of the line is high; clearing forces the idle level
  always_comb begin
    if (soft_clr) begin
      sync_d = '1;
      prev_d = 1'b1;
    end else begin
      sync_d = {sync_q[STAGES-2:0], line};
      prev_d = sync_q[STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/etu_down_cnt.sv
module etu_down_cnt #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_clr,
  input  logic         halt,
  input  logic         arm,
  input  logic         reload_en,
  input  logic         tick,
  input  logic         clr_flag,
  input  logic [W-1:0] load_val,
  output logic         busy,
  output logic         expired
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         run_q;
  logic         run_d;
  logic         flag_q;
  logic         flag_d;
  logic         hit;

  // priority: clear, halt, arm, tick
  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    hit   = 1'b0;
    if (soft_clr) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else if (halt) begin
      run_d = 1'b0;
    end else if (arm) begin
      cnt_d = load_val;
      run_d = 1'b1;
    end else if (run_q && tick) begin
      if (cnt_q <= W'(1)) begin
        hit   = 1'b1;
        cnt_d = reload_en ? load_val : '0;
        run_d = reload_en;
      end else begin
        cnt_d = cnt_q - W'(1);
      end
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (soft_clr)      flag_d = 1'b0;
    else if (hit)      flag_d = 1'b1;
    else if (clr_flag) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign busy    = run_q;
  assign expired = flag_q;

endmodule

// File: rtl/etu_timeout_ctr.sv
module etu_timeout_ctr
  import etu_tmo_pkg::*;
#(
  parameter  int BYTE_W      = 8,
  parameter  int LD_BYTES    = 3,
  parameter  int SYNC_STAGES = 2,
  localparam int ADDR_W      = $clog2(LD_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uart_rst_n,
  input  logic              etu_tick,
  input  logic              card_io,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              stat_rd,
  output logic [1:0]        irq_o,
  output logic [1:0]        busy_o
);

  localparam int TOT_W = LD_BYTES * BYTE_W;
  localparam int LO_W  = (LD_BYTES - 1) * BYTE_W;

  logic             soft_clr;
  logic [TOT_W-1:0] load_q;
  tmo_cfg_t         cfg_q;
  logic             cfg_wr;
  logic             wr_top_q;
  logic             wr_mid_q;
  logic             io_fall;

  logic [TOT_W-1:0]  load_a;
  logic [BYTE_W-1:0] load_b;
  logic              arm_a;
  logic              arm_b;
  logic              reload_a;
  logic              reload_b;
  logic              busy_a;
  logic              busy_b;
  logic              flag_a;
  logic              flag_b;

  assign soft_clr = ~uart_rst_n;

  etu_tmo_regs #(
    .BYTE_W  (BYTE_W),
    .LD_BYTES(LD_BYTES),
    .ADDR_W  (ADDR_W)
  ) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_clr(soft_clr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .load_q  (load_q),
    .cfg_q   (cfg_q),
    .cfg_wr  (cfg_wr),
    .wr_top_q(wr_top_q),
    .wr_mid_q(wr_mid_q)
  );

  etu_io_fall #(
    .STAGES(SYNC_STAGES)
  ) edge_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_clr(soft_clr),
    .line    (card_io),
    .fall    (io_fall)
  );

  // layout selection: split keeps the lower bytes for A and the top byte for B
  always_comb begin
    if (cfg_q.split) load_a = {{BYTE_W{1'b0}}, load_q[LO_W-1:0]};
    else             load_a = load_q;
    load_b = load_q[TOT_W-1 -: BYTE_W];
  end

  always_comb begin
    logic wr_arm_a;
    wr_arm_a = cfg_q.split ? wr_mid_q : wr_top_q;
    arm_a    = (arms_on_write(cfg_q.mode_a) && wr_arm_a) ||
               ((cfg_q.mode_a == START_EDGE) && io_fall && !busy_a);
    arm_b    = cfg_q.split &&
               ((arms_on_write(cfg_q.mode_b) && wr_top_q) ||
                ((cfg_q.mode_b == START_EDGE) && io_fall && !busy_b));
    reload_a = (cfg_q.mode_a == START_RELOAD);
    reload_b = cfg_q.split && (cfg_q.mode_b == START_RELOAD);
  end

  etu_down_cnt #(
    .W(TOT_W)
  ) cnt_a_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .halt     (cfg_wr),
    .arm      (arm_a),
    .reload_en(reload_a),
    .tick     (etu_tick),
    .clr_flag (stat_rd),
    .load_val (load_a),
    .busy     (busy_a),
    .expired  (flag_a)
  );

  etu_down_cnt #(
    .W(BYTE_W)
  ) cnt_b_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .halt     (cfg_wr),
    .arm      (arm_b),
    .reload_en(reload_b),
    .tick     (etu_tick),
    .clr_flag (stat_rd),
    .load_val (load_b),
    .busy     (busy_b),
    .expired  (flag_b)
  );

  assign irq_o  = {flag_b, flag_a};
  assign busy_o = {busy_b, busy_a};

endmodule

// File: rtl/etu_timeout_ctr_chk.sv
module etu_timeout_ctr_chk
  import etu_tmo_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       uart_rst_n,
  input logic       etu_tick,
  input logic       stat_rd,
  input logic       cfg_wr,
  input tmo_cfg_t   cfg_q,
  input logic [1:0] irq_o,
  input logic [1:0] busy_o
);

  p_soft_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_rst_n |=> (irq_o == 2'b00 && busy_o == 2'b00));

  p_expiry_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[0]) |-> $past(etu_tick));

  p_stop_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o[0]) && cfg_q.mode_a != START_RELOAD) |-> !busy_o[0]);

  p_reload_runs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_o[0]) && cfg_q.mode_a == START_RELOAD) |-> busy_o[0]);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o[0] && !stat_rd && uart_rst_n) |=> irq_o[0]);

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o[0] && stat_rd && uart_rst_n && !etu_tick) |=> !irq_o[0]);

  p_cfg_halts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (busy_o == 2'b00));

  p_single_b_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.split |-> !busy_o[1]);

endmodule

bind etu_timeout_ctr etu_timeout_ctr_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .uart_rst_n(uart_rst_n),
  .etu_tick  (etu_tick),
  .stat_rd   (stat_rd),
  .cfg_wr    (cfg_wr),
  .cfg_q     (cfg_q),
  .irq_o     (irq_o),
  .busy_o    (busy_o)
);

// File: tb/etu_timeout_ctr_tb_top.sv
module etu_timeout_ctr_tb_top;

  logic       clk;
  logic       rst_n;
  logic       uart_rst_n;
  logic       etu_tick;
  logic       card_io;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       stat_rd;
  logic [1:0] irq_o;
  logic [1:0] busy_o;

  int checks;
  int fails;
  bit done;

  typedef struct {
    logic [1:0] irq;
    logic [1:0] busy;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  etu_timeout_ctr dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .uart_rst_n(uart_rst_n),
    .etu_tick  (etu_tick),
    .card_io   (card_io),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .stat_rd   (stat_rd),
    .irq_o     (irq_o),
    .busy_o    (busy_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // monitor: pops expected items shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (irq_o !== e.irq || busy_o !== e.busy) begin
          fails++;
          $display("FAIL %s: irq=%b busy=%b expected irq=%b busy=%b",
                   e.tag, irq_o, busy_o, e.irq, e.busy);
        end
      end
    end
  end

  task automatic expect_st(input logic [1:0] irq, input logic [1:0] busy, input string tag);
    exp_t e;
    e.irq  = irq;
    e.busy = busy;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic tick_n(input int n);
    repeat (n) begin
      @(negedge clk);
      etu_tick = 1'b1;
      @(negedge clk);
      etu_tick = 1'b0;
    end
  endtask

  task automatic tick_hold(input int n);
    @(negedge clk);
    etu_tick = 1'b1;
    repeat (n) @(negedge clk);
    etu_tick = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic load3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    wr(2'd0, b0);
    wr(2'd1, b1);
    wr(2'd2, b2);
  endtask

  initial begin
    rst_n = 1'b0; uart_rst_n = 1'b0; etu_tick = 1'b0; card_io = 1'b1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; stat_rd = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    expect_st(2'b00, 2'b00, "R1 reset state");

    // R2: writes ignored while UART reset low
    wr(2'd3, 8'h02);
    load3(8'h01, 8'h00, 8'h00);
    idle(2);
    expect_st(2'b00, 2'b00, "R2 writes ignored in UART reset");
    uart_rst_n = 1'b1;
    wr(2'd2, 8'h00);
    idle(2);
    expect_st(2'b00, 2'b00, "R2 config defaulted to off");

    // R3/R4: single layout write-start, load 3
    wr(2'd3, 8'h02);
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h00);
    idle(2);
    expect_st(2'b00, 2'b00, "R4 middle byte does not arm single");
    wr(2'd2, 8'h00);
    tick_n(2);
    expect_st(2'b00, 2'b01, "R4 busy before Nth tick");
    tick_n(1);
    expect_st(2'b01, 2'b00, "R4 expiry on Nth tick R12 B quiet");
    tick_n(2);
    expect_st(2'b01, 2'b00, "R7 stopped at zero");
    rd();
    expect_st(2'b00, 2'b00, "R10 read clears flag");

    // R4: middle byte weight 256
    load3(8'h00, 8'h01, 8'h00);
    tick_n(255);
    expect_st(2'b00, 2'b01, "R4 load 256 busy after 255");
    tick_n(1);
    expect_st(2'b01, 2'b00, "R4 load 256 expires at 256");
    rd();

    // R4: top byte weight 65536
    load3(8'h00, 8'h00, 8'h01);
    tick_hold(65535);
    expect_st(2'b00, 2'b01, "R4 load 65536 busy after 65535");
    tick_n(1);
    expect_st(2'b01, 2'b00, "R4 load 65536 expires");
    rd();

    // R6: zero load
    load3(8'h00, 8'h00, 8'h00);
    tick_n(1);
    expect_st(2'b01, 2'b00, "R6 zero load first tick");
    rd();
    expect_st(2'b00, 2'b00, "R10 cleared after zero load");

    // R5: split layout, A=5 (16-bit), B=3 (8-bit)
    wr(2'd3, 8'h0B);
    load3(8'h05, 8'h00, 8'h03);
    tick_n(3);
    expect_st(2'b10, 2'b01, "R5 B expires first");
    tick_n(2);
    expect_st(2'b11, 2'b00, "R5 A expires at 5");
    rd();
    expect_st(2'b00, 2'b00, "R10 read clears both");

    // R8: autoreload load 2
    wr(2'd3, 8'h06);
    load3(8'h02, 8'h00, 8'h00);
    tick_n(2);
    expect_st(2'b01, 2'b01, "R8 expiry keeps running");
    rd();
    tick_n(1);
    expect_st(2'b00, 2'b01, "R8 mid reload period");
    tick_n(1);
    expect_st(2'b01, 2'b01, "R8 second expiry");
    wr(2'd3, 8'h06);
    expect_st(2'b01, 2'b00, "R11 config write halts");
    rd();

    // R9: start-bit mode, load 3
    wr(2'd3, 8'h04);
    load3(8'h03, 8'h00, 8'h00);
    idle(2);
    expect_st(2'b00, 2'b00, "R9 writes do not arm");
    card_io = 1'b0;
    idle(4);
    expect_st(2'b00, 2'b01, "R9 falling edge arms");
    tick_n(1);
    card_io = 1'b1;
    idle(4);
    card_io = 1'b0;
    idle(4);
    tick_n(2);
    expect_st(2'b01, 2'b00, "R9 edge while busy ignored");
    rd();
    card_io = 1'b1;
    idle(4);
    expect_st(2'b00, 2'b00, "R9 rising edge no arm");

    // R2: UART reset mid-run
    wr(2'd3, 8'h02);
    load3(8'h09, 8'h00, 8'h00);
    tick_n(1);
    expect_st(2'b00, 2'b01, "R2 running before UART reset");
    uart_rst_n = 1'b0;
    idle(1);
    expect_st(2'b00, 2'b00, "R2 UART reset stops counter");
    uart_rst_n = 1'b1;
    wr(2'd2, 8'h00);
    idle(2);
    expect_st(2'b00, 2'b00, "R2 config cleared by UART reset");

    idle(3);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule